// File: doc/BRIEF.md
# Button-driven paddle position controller

This block holds the vertical position of a rectangular paddle that sits in a fixed band of columns on a 640x480 raster display. The renderer feeds it the current pixel coordinates every clock. The block watches those coordinates for one particular raster position and uses that single clock as its once-per-frame update moment. At that moment a held button moves the paddle one fixed step up or down. A move is refused when it would push any part of the paddle off the visible area.

For every pixel, the block also reports whether that pixel lies on the paddle, and it supplies the paddle's colour code. The button inputs must already be synchronised to the clock and debounced. Sync generation and mixing the paddle with other screen objects are left to neighbouring logic.

Top module: `paddle_top`

## Requirements
- R1: After asynchronous reset the paddle's top row is 0, so the paddle covers rows 0 through 71.
- R2: The paddle covers columns 600 through 603 inclusive. Columns 599 and 604 are never on the paddle.
- R3: The paddle is 72 rows tall. The on-paddle output is high exactly for rows top through top+71 within the paddle columns.
- R4: The position changes only in the one clock where the pixel row is 481 and the pixel column is 0. A held button at any other coordinate, for example (row 481, column 1), (row 480, column 0) or (row 0, column 0), leaves the position unchanged.
- R5: On a frame strobe with button bit 1 (down) high, the top row increases by 4.
- R6: On a frame strobe with only button bit 0 (up) high, the top row decreases by 4.
- R7: When both button bits are high and a down move is allowed, the paddle moves down.
- R8: A down move is taken only if the bottom row (top+71) is at most 475. Repeated down moves starting from 0 stop with the top row at 408.
- R9: An up move is taken only if the top row is at least 4. An up request at top row 0 leaves the paddle in place.
- R10: When both button bits are high, down is refused by its limit and up is allowed, the paddle moves up by 4.
- R11: The colour output is always the 3-bit value 010.
- R12: A frame strobe with no button held leaves the position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Asynchronous reset, active high |
| btn | input | 2 | Button requests: bit 1 moves down, bit 0 moves up |
| pixX | input | 10 | Current pixel column |
| pixY | input | 10 | Current pixel row |
| paddleOn | output | 1 | High when the current pixel lies on the paddle |
| paddleRgb | output | 3 | Paddle colour code |

## Verification
Two things can fall in the same frame strobe: the down-over-up priority and a limit check. At the bottom limit the down request is refused, and the up request behind it must then take effect. The bench drives the paddle to the bottom with repeated down strobes, then gives one strobe with both buttons held. It judges the result by scanning the on-paddle output over all rows and expects the top row to go from 408 to 404. The same scan also confirms that the paddle stays at the limit when only the down button is held there.

// File: rtl/paddle_pkg.sv
package paddle_pkg;

  // Move requests that the control side hands to the datapath
  typedef struct packed {
    logic stepDn;
    logic stepUp;
  } paddle_step_t;

endpackage

// File: rtl/paddle_ctrl.sv
module paddle_ctrl
  import paddle_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int MAX_Y    = 480,
  parameter int PAD_H    = 72,
  parameter int STEP     = 4,
  parameter int TICK_ROW = 481,
  parameter int TICK_COL = 0
) (
  input  logic [1:0]         btn,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [COORD_W-1:0] topRow,
  input  logic [COORD_W-1:0] botRow,
  output logic               frameTick,
  output paddle_step_t       step
);

  localparam logic [COORD_W-1:0] TickRow = COORD_W'(TICK_ROW);
  localparam logic [COORD_W-1:0] TickCol = COORD_W'(TICK_COL);
  localparam logic [COORD_W-1:0] DnLimit = COORD_W'(MAX_Y - 1 - STEP);
  localparam logic [COORD_W-1:0] UpLimit = COORD_W'(STEP);

  logic dnOk;
  logic upOk;

  // Single-clock strobe decoded from one raster position
  assign frameTick = (pixY == TickRow) && (pixX == TickCol);

  // The whole paddle must stay on screen after the move
  assign dnOk = (botRow <= DnLimit);
  assign upOk = (topRow >= UpLimit);

  // Down has priority; up is considered only when down is not taken
  always_comb begin
    step = '0;
    if (frameTick) begin
      if (btn[1] && dnOk) begin
        step.stepDn = 1'b1;
      end else if (btn[0] && upOk) begin
        step.stepUp = 1'b1;
      end
    end
  end

endmodule

// File: rtl/paddle_dp.sv
module paddle_dp
  import paddle_pkg::*;
#(
  parameter int         COORD_W = 10,
  parameter int         PAD_H   = 72,
  parameter int         STEP    = 4,
  parameter int         COL_L   = 600,
  parameter int         COL_R   = 603,
  parameter logic [2:0] COLOUR  = 3'b010
) (
  input  logic               clk,
  input  logic               rst,
  input  paddle_step_t       step,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  output logic [COORD_W-1:0] topRow,
  output logic [COORD_W-1:0] botRow,
  output logic               paddleOn,
  output logic [2:0]         paddleRgb
);

  localparam logic [COORD_W-1:0] StepV  = COORD_W'(STEP);
  localparam logic [COORD_W-1:0] HeightM1 = COORD_W'(PAD_H - 1);
  localparam logic [COORD_W-1:0] ColL   = COORD_W'(COL_L);
  localparam logic [COORD_W-1:0] ColR   = COORD_W'(COL_R);

  logic [COORD_W-1:0] topNext;
  logic               inCols;
  logic               inRows;

  always_comb begin
    topNext = topRow;
    if (step.stepDn) begin
      topNext = topRow + StepV;
    end else if (step.stepUp) begin
      topNext = topRow - StepV;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      topRow <= '0;
    end else begin
      topRow <= topNext;
    end
  end

  assign botRow    = topRow + HeightM1;
  assign inCols    = (pixX >= ColL) && (pixX <= ColR);
  assign inRows    = (pixY >= topRow) && (pixY <= botRow);
  assign paddleOn  = inCols && inRows;
  assign paddleRgb = COLOUR;

endmodule

// File: rtl/paddle_top.sv
module paddle_top
  import paddle_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int MAX_Y    = 480,
  parameter int PAD_H    = 72,
  parameter int STEP     = 4,
  parameter int COL_L    = 600,
  parameter int COL_R    = 603,
  parameter int TICK_ROW = 481,
  parameter int TICK_COL = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         btn,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  output logic               paddleOn,
  output logic [2:0]         paddleRgb
);

  paddle_step_t       step;
  logic               frameTick;
  logic [COORD_W-1:0] topRow;
  logic [COORD_W-1:0] botRow;

  paddle_ctrl #(
    .COORD_W(COORD_W), .MAX_Y(MAX_Y), .PAD_H(PAD_H), .STEP(STEP),
    .TICK_ROW(TICK_ROW), .TICK_COL(TICK_COL)
  ) u_ctrl (
    .btn(btn), .pixX(pixX), .pixY(pixY),
    .topRow(topRow), .botRow(botRow),
    .frameTick(frameTick), .step(step)
  );

  paddle_dp #(
    .COORD_W(COORD_W), .PAD_H(PAD_H), .STEP(STEP),
    .COL_L(COL_L), .COL_R(COL_R), .COLOUR(3'b010)
  ) u_dp (
    .clk(clk), .rst(rst), .step(step),
    .pixX(pixX), .pixY(pixY),
    .topRow(topRow), .botRow(botRow),
    .paddleOn(paddleOn), .paddleRgb(paddleRgb)
  );

endmodule

// File: rtl/paddle_chk.sv
module paddle_chk #(
  parameter int COORD_W  = 10,
  parameter int MAX_Y    = 480,
  parameter int PAD_H    = 72,
  parameter int STEP     = 4,
  parameter int COL_L    = 600,
  parameter int COL_R    = 603,
  parameter int TICK_ROW = 481,
  parameter int TICK_COL = 0
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         btn,
  input logic [COORD_W-1:0] pixX,
  input logic [COORD_W-1:0] pixY,
  input logic [COORD_W-1:0] topRow,
  input logic               stepDn,
  input logic               stepUp,
  input logic               paddleOn
);

  localparam logic [COORD_W-1:0] TopMax   = COORD_W'(MAX_Y - PAD_H);
  localparam logic [COORD_W-1:0] DnTopMax = COORD_W'(MAX_Y - PAD_H - STEP);
  localparam logic [COORD_W-1:0] StepV    = COORD_W'(STEP);

  logic atTick;
  assign atTick = (pixY == COORD_W'(TICK_ROW)) && (pixX == COORD_W'(TICK_COL));

  assert_hold_off_tick_R4: assert property (@(posedge clk) disable iff (rst)
    !atTick |=> $stable(topRow));

  assert_stay_on_screen_R8: assert property (@(posedge clk) disable iff (rst)
    topRow <= TopMax);

  assert_move_down_R5: assert property (@(posedge clk) disable iff (rst)
    (atTick && btn[1] && topRow <= DnTopMax) |=> (topRow == $past(topRow) + StepV));

  assert_move_up_R6: assert property (@(posedge clk) disable iff (rst)
    (atTick && btn == 2'b01 && topRow >= StepV) |=> (topRow == $past(topRow) - StepV));

  assert_fallthrough_up_R10: assert property (@(posedge clk) disable iff (rst)
    (atTick && btn == 2'b11 && topRow > DnTopMax && topRow >= StepV)
      |=> (topRow == $past(topRow) - StepV));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (atTick && btn == 2'b00) |=> $stable(topRow));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stepDn, stepUp}));

  assert_on_within_cols_R2: assert property (@(posedge clk) disable iff (rst)
    paddleOn |-> (pixX >= COORD_W'(COL_L) && pixX <= COORD_W'(COL_R)));

endmodule

bind paddle_top paddle_chk #(
  .COORD_W(COORD_W), .MAX_Y(MAX_Y), .PAD_H(PAD_H), .STEP(STEP),
  .COL_L(COL_L), .COL_R(COL_R), .TICK_ROW(TICK_ROW), .TICK_COL(TICK_COL)
) u_chk (
  .clk(clk), .rst(rst), .btn(btn), .pixX(pixX), .pixY(pixY),
  .topRow(topRow), .stepDn(step.stepDn), .stepUp(step.stepUp),
  .paddleOn(paddleOn)
);

// File: tb/sim_paddle_top.sv
`timescale 1ns/1ps
module sim_paddle_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] btn = 2'b00;
  logic [9:0] pixX = 10'd0;
  logic [9:0] pixY = 10'd0;
  logic       paddleOn;
  logic [2:0] paddleRgb;

  int checks = 0;
  int errors = 0;
  int modelTop = 0;
  int pushed = 0;
  int acked = 0;
  int expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  paddle_top u0 (
    .clk(clk), .rst(rst), .btn(btn), .pixX(pixX), .pixY(pixY),
    .paddleOn(paddleOn), .paddleRgb(paddleRgb)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements
  function automatic int nextTop(input int t, input logic [1:0] b);
    if (b[1] && (t + 71) <= 475) return t + 4;
    if (b[0] && t >= 4) return t - 4;
    return t;
  endfunction

  task automatic pushExp(input string tag);
    expQ.push_back(modelTop);
    tagQ.push_back(tag);
    pushed++;
    wait (acked == pushed);
  endtask

  // One frame strobe with the given buttons held
  task automatic frame(input logic [1:0] b, input string tag);
    @(negedge clk);
    btn = b; pixX = 10'd0; pixY = 10'd481;
    @(negedge clk);
    btn = 2'b00; pixY = 10'd0;
    modelTop = nextTop(modelTop, b);
    pushExp(tag);
  endtask

  // Buttons held at a near-miss coordinate for a few clocks
  task automatic nearMiss(input logic [1:0] b, input int x, input int y, input string tag);
    @(negedge clk);
    btn = b; pixX = 10'(x); pixY = 10'(y);
    repeat (3) @(negedge clk);
    btn = 2'b00; pixX = 10'd0; pixY = 10'd0;
    pushExp(tag);
  endtask

  // Monitor: measures the paddle through its on-pixel output
  initial begin
    forever begin
      int first, last, cnt, e;
      string tg;
      wait (expQ.size() > 0);
      @(negedge clk);
      first = -1; last = -1; cnt = 0;
      pixX = 10'd601;
      for (int y = 0; y < 480; y++) begin
        pixY = 10'(y);
        #1;
        if (paddleOn) begin
          if (first < 0) first = y;
          last = y;
          cnt++;
        end
      end
      pixX = 10'd0; pixY = 10'd0;
      e = expQ.pop_front();
      tg = tagQ.pop_front();
      check({tg, " top"}, first, e);
      check("R3 height", cnt, 72);
      check("R3 bottom", last, e + 71);
      check("R11 colour", int'(paddleRgb), 2);
      acked++;
    end
  end

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelTop = 0;
    pushExp("R1 reset");

    // Column edges at a row inside the paddle
    pixY = 10'd10;
    for (int x = 598; x <= 605; x++) begin
      pixX = 10'(x);
      #1;
      check($sformatf("R2 col %0d", x), int'(paddleOn), (x >= 600 && x <= 603) ? 1 : 0);
    end
    pixX = 10'd0; pixY = 10'd0;

    frame(2'b00, "R12 idle");
    frame(2'b01, "R9 up at zero");
    frame(2'b10, "R5 down");
    frame(2'b10, "R5 down");
    frame(2'b10, "R5 down");
    frame(2'b11, "R7 both down");
    frame(2'b01, "R6 up");
    nearMiss(2'b10, 1, 481, "R4 col1");
    nearMiss(2'b10, 0, 480, "R4 row480");
    nearMiss(2'b01, 0, 0, "R4 origin");

    for (int i = 0; i < 110; i++) frame(2'b10, "R8 down run");
    check("R8 clamp", modelTop, 408);
    frame(2'b10, "R8 held at limit");
    frame(2'b11, "R10 fallthrough up");
    for (int i = 0; i < 110; i++) frame(2'b01, "R9 up run");
    frame(2'b01, "R9 held at zero");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule